// File: doc/BRIEF.md
# Phase-Error Lock Detector

This block watches a phase-locked loop's phase detector and reports when the loop has settled. Each comparison cycle starts with a rising edge on either the divided reference pulse or the divided feedback pulse. It ends when the other pulse rises. The block counts sample-clock periods between the two rising edges and sorts the result into one of three grades: small, mid or large. The two thresholds are derived from a nominal sample period and two time windows, all given as parameters in picoseconds. The defaults are a 5000 ps sample period, a 15000 ps set window and a 25000 ps clear window.

The lock flag is a hysteresis latch. It goes high only after a run of consecutive small-error cycles. The run length is 3 or 5, picked by a select input. The flag then stays high until a single large-error cycle occurs. Mid-grade cycles never clear the flag, but they do restart an unfinished run. If the same pulse arrives twice before its partner, the detector takes that as a missing edge over a full period and grades the cycle as large. Power-down clears the whole detector.

Top module: `pd_lock_detect`

## Requirements
- R1: `lock_o` is 0 after `rst_ni` is released. Holding `pwr_dn_i` high for a cycle drives `lock_o` to 0 and discards any partial run of small cycles.
- R2: A cycle whose edge separation `k` (in sample periods) satisfies `k*SAMPLE_PS < SET_WIN_PS` is small. The defaults make this k = 0, 1 or 2.
- R3: With `long_qual_i` = 0, `lock_o` rises on the third consecutive small cycle and not before.
- R4: With `long_qual_i` = 1, `lock_o` rises on the fifth consecutive small cycle and not before.
- R5: While `lock_o` is high, small and mid cycles leave it high. A mid cycle satisfies `SET_WIN_PS <= k*SAMPLE_PS <= CLR_WIN_PS`; the defaults make this k = 3, 4 or 5.
- R6: Any cycle with `k*SAMPLE_PS > CLR_WIN_PS` (the defaults make this k >= 6) drives `lock_o` to 0 and restarts the run count.
- R7: While `lock_o` is low, a mid cycle sets the run count back to zero.
- R8: If a pulse rises again before its partner has risen, the pending cycle is graded large. The new rise then opens a fresh measurement window.
- R9: Grading does not depend on which pulse leads. A feedback-first cycle is graded the same as a reference-first cycle with the same separation.
- R10: The rise of `lock_o` caused by a cycle appears two clock edges after the edge that samples the completing pulse: one edge for grading and one for the flag.
- R11: The pulse inputs are detected on their rising edges. An input held high for several cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock used to measure phase error |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_dn_i | input | 1 | Power-down; clears the detector while high |
| ref_pulse_i | input | 1 | Divided reference pulse |
| fb_pulse_i | input | 1 | Divided feedback pulse |
| long_qual_i | input | 1 | Run-length select: 0 needs 3 small cycles, 1 needs 5 |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The main sweep covers both run-length selects and both lead orders. For each combination it first applies a run of identical cycles at every separation from 0 to 8 periods, then one follow-up cycle at every separation. The first run shows whether each separation is graded small, and so whether it reaches lock. The follow-up cycle separates the three grades: large clears lock, mid keeps it, and mid or small move the run count. Directed sequences cover the rest: a mid cycle in the middle of a run, a pulse that repeats before its partner, inputs held high for several cycles, power-down in the middle of a run, and the exact cycle in which the flag rises.

// File: rtl/ld_pkg.sv
package ld_pkg;

  typedef enum logic [1:0] {
    ERR_SMALL = 2'd0,
    ERR_MID   = 2'd1,
    ERR_LARGE = 2'd2
  } err_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_FB  = 2'd1,
    PH_WAIT_REF = 2'd2
  } ph_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/ld_edge_det.sv
module ld_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end

    assign rise_o[g] = sig_i[g] & ~prev_q[g];

    AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]); // R11
  end

endmodule

// File: rtl/ld_phase_timer.sv
module ld_phase_timer
  import ld_pkg::*;
#(
  parameter int unsigned SET_LIM = 3,
  parameter int unsigned CLR_LIM = 5,
  localparam int unsigned CNT_SAT = CLR_LIM + 1,
  localparam int unsigned CNT_W   = $clog2(CNT_SAT + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     ref_rise_i,
  input  logic     fb_rise_i,
  output logic     meas_vld_o,
  output err_cls_e meas_cls_o
);

  ph_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             done;
  err_cls_e         cls;

  function automatic err_cls_e grade(input logic [CNT_W-1:0] k);
    if (32'(k) < SET_LIM)      return ERR_SMALL;
    else if (32'(k) > CLR_LIM) return ERR_LARGE;
    else                       return ERR_MID;
  endfunction

  assign cnt_inc = (cnt_q == CNT_W'(CNT_SAT)) ? cnt_q : cnt_q + CNT_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    cls   = ERR_LARGE;
    unique case (st_q)
      PH_IDLE: begin
        if (ref_rise_i && fb_rise_i) begin
          done = 1'b1;
          cls  = grade('0);
        end else if (ref_rise_i) begin
          st_d  = PH_WAIT_FB;
          cnt_d = CNT_W'(1);
        end else if (fb_rise_i) begin
          st_d  = PH_WAIT_REF;
          cnt_d = CNT_W'(1);
        end
      end
      PH_WAIT_FB: begin
        if (fb_rise_i) begin
          done  = 1'b1;
          cls   = grade(cnt_q);
          st_d  = ref_rise_i ? PH_WAIT_FB : PH_IDLE;
          cnt_d = CNT_W'(1);
        end else if (ref_rise_i) begin
          // partner missed a whole period
          done  = 1'b1;
          cls   = ERR_LARGE;
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_WAIT_REF: begin
        if (ref_rise_i) begin
          done  = 1'b1;
          cls   = grade(cnt_q);
          st_d  = fb_rise_i ? PH_WAIT_REF : PH_IDLE;
          cnt_d = CNT_W'(1);
        end else if (fb_rise_i) begin
          done  = 1'b1;
          cls   = ERR_LARGE;
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_cls_o <= ERR_SMALL;
    end else if (clr_i) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      meas_vld_o <= 1'b0;
      meas_cls_o <= ERR_SMALL;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      meas_vld_o <= done;
      meas_cls_o <= cls;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != PH_IDLE) |-> (cnt_q != '0 && cnt_q <= CNT_W'(CNT_SAT))); // R2

  AST_REPEAT_LARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && st_q == PH_WAIT_FB && ref_rise_i && !fb_rise_i)
      |=> (meas_vld_o && meas_cls_o == ERR_LARGE)); // R8

  AST_VLD_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld_o |-> $past(ref_rise_i || fb_rise_i)); // R9

endmodule

// File: rtl/ld_run_qual.sv
module ld_run_qual
  import ld_pkg::*;
#(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 5,
  localparam int unsigned RUN_W    = $clog2(LONG_RUN + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     long_sel_i,
  input  logic     meas_vld_i,
  input  err_cls_e meas_cls_i,
  output logic     lock_o
);

  logic [RUN_W-1:0] run_q, run_nx, need;
  logic             lock_q;

  assign need   = long_sel_i ? RUN_W'(LONG_RUN) : RUN_W'(SHORT_RUN);
  assign run_nx = run_q + RUN_W'(1);
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (clr_i) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (meas_vld_i) begin
      unique case (meas_cls_i)
        ERR_SMALL: begin
          if (!lock_q) begin
            if (run_nx >= need) begin
              lock_q <= 1'b1;
              run_q  <= '0;
            end else begin
              run_q  <= run_nx;
            end
          end
        end
        ERR_MID: begin
          if (!lock_q) run_q <= '0;
        end
        default: begin
          lock_q <= 1'b0;
          run_q  <= '0;
        end
      endcase
    end
  end

  AST_PD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!lock_q && run_q == '0)); // R1

  AST_RISE_ON_SMALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(meas_vld_i && meas_cls_i == ERR_SMALL)); // R3

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RUN_W'(LONG_RUN)); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !clr_i && !(meas_vld_i && meas_cls_i == ERR_LARGE)) |=> lock_q); // R5

  AST_LARGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && meas_cls_i == ERR_LARGE) |=> !lock_q); // R6

  AST_MID_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !lock_q && meas_vld_i && meas_cls_i == ERR_MID) |=> (run_q == '0)); // R7

endmodule

// File: rtl/pd_lock_detect.sv
module pd_lock_detect
  import ld_pkg::*;
#(
  parameter int unsigned SAMPLE_PS  = 5000,
  parameter int unsigned SET_WIN_PS = 15000,
  parameter int unsigned CLR_WIN_PS = 25000,
  parameter int unsigned SHORT_RUN  = 3,
  parameter int unsigned LONG_RUN   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_i,
  input  logic ref_pulse_i,
  input  logic fb_pulse_i,
  input  logic long_qual_i,
  output logic lock_o
);

  // small: k < SET_LIM ; large: k > CLR_LIM (k in sample periods)
  localparam int unsigned SET_LIM = ceil_div(SET_WIN_PS, SAMPLE_PS);
  localparam int unsigned CLR_LIM = CLR_WIN_PS / SAMPLE_PS;

  logic [1:0] rise;
  logic       meas_vld;
  err_cls_e   meas_cls;

  ld_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({fb_pulse_i, ref_pulse_i}),
    .rise_o (rise)
  );

  ld_phase_timer #(
    .SET_LIM (SET_LIM),
    .CLR_LIM (CLR_LIM)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pwr_dn_i),
    .ref_rise_i (rise[0]),
    .fb_rise_i  (rise[1]),
    .meas_vld_o (meas_vld),
    .meas_cls_o (meas_cls)
  );

  ld_run_qual #(
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pwr_dn_i),
    .long_sel_i (long_qual_i),
    .meas_vld_i (meas_vld),
    .meas_cls_i (meas_cls),
    .lock_o     (lock_o)
  );

endmodule

// File: tb/sim_pd_lock_detect.sv
`timescale 1ns/1ps
module sim_pd_lock_detect;

  localparam int SAMPLE_PS = 5000;
  localparam int SET_PS    = 15000;
  localparam int CLR_PS    = 25000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b0;
  logic ref_p = 1'b0;
  logic fb_p = 1'b0;
  logic ldp = 1'b0;
  logic lock;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit exp_lock = 0;
  int exp_run = 0;

  always #2.5 clk = ~clk;

  pd_lock_detect u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_dn_i    (pd),
    .ref_pulse_i (ref_p),
    .fb_pulse_i  (fb_p),
    .long_qual_i (ldp),
    .lock_o      (lock)
  );

  // 0 small, 1 mid, 2 large
  function automatic int grade(input int k);
    if (k * SAMPLE_PS < SET_PS) return 0;
    if (k * SAMPLE_PS > CLR_PS) return 2;
    return 1;
  endfunction

  function automatic void model(input int g);
    int need;
    need = ldp ? 5 : 3;
    if (g == 2) begin
      exp_lock = 0; exp_run = 0;
    end else if (g == 1) begin
      if (!exp_lock) exp_run = 0;
    end else if (!exp_lock) begin
      exp_run++;
      if (exp_run >= need) begin exp_lock = 1; exp_run = 0; end
    end
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s lock actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic power_down();
    @(negedge clk); pd = 1'b1;
    @(negedge clk); pd = 1'b0;
    repeat (2) @(negedge clk);
    exp_lock = 0; exp_run = 0;
  endtask

  // first edge, then partner k sample periods later, then idle
  task automatic phase_cycle(input bit ref_first, input int k);
    @(negedge clk);
    if (k == 0) begin ref_p = 1'b1; fb_p = 1'b1; end
    else if (ref_first) ref_p = 1'b1;
    else fb_p = 1'b1;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      ref_p = 1'b0; fb_p = 1'b0;
      if (i == k) begin
        if (ref_first) fb_p = 1'b1; else ref_p = 1'b1;
      end
    end
    @(negedge clk);
    ref_p = 1'b0; fb_p = 1'b0;
    repeat (3) @(negedge clk);
    model(grade(k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lock, 1'b0, "R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(lock, 1'b0, "R1 after release");

    // R10: exact update cycle
    ldp = 1'b0;
    power_down();
    phase_cycle(1, 1);
    phase_cycle(1, 1);
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0; fb_p = 1'b1;
    @(negedge clk); fb_p = 1'b0;
    check(lock, 1'b0, "R10 one edge after");
    @(negedge clk);
    check(lock, 1'b1, "R10 two edges after");
    exp_lock = 1; exp_run = 0;

    // R1: power-down while locked, partial run discarded
    power_down();
    check(lock, 1'b0, "R1 pd clears lock");
    phase_cycle(1, 0);
    phase_cycle(1, 0);
    power_down();
    phase_cycle(1, 0);
    phase_cycle(1, 0);
    check(lock, 1'b0, "R1 run discarded");
    phase_cycle(1, 0);
    check(lock, exp_lock, "R1 relock");

    // R7: mid cycle in a run
    power_down();
    phase_cycle(1, 1);
    phase_cycle(0, 2);
    phase_cycle(1, 4);
    phase_cycle(1, 1);
    phase_cycle(0, 0);
    check(lock, 1'b0, "R7 mid restarts run");
    phase_cycle(1, 2);
    check(lock, 1'b1, "R7 run after restart");

    // R9: feedback leading
    power_down();
    repeat (3) phase_cycle(0, 2);
    check(lock, 1'b1, "R9 fb leads small");
    phase_cycle(0, 6);
    check(lock, 1'b0, "R9 fb leads large");

    // R8: repeated reference edge
    power_down();
    repeat (3) phase_cycle(1, 0);
    check(lock, 1'b1, "R8 locked before");
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0;
    repeat (2) @(negedge clk);
    ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0; fb_p = 1'b1;
    @(negedge clk); fb_p = 1'b0;
    repeat (3) @(negedge clk);
    model(2); model(grade(1));
    check(lock, 1'b0, "R8 repeat is large");
    phase_cycle(1, 0);
    check(lock, 1'b0, "R8 new window counted");
    phase_cycle(1, 0);
    check(lock, exp_lock, "R8 relock");

    // R11: reference held high counts once
    power_down();
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); ref_p = 1'b1; fb_p = 1'b1;
      @(negedge clk); fb_p = 1'b0;
      repeat (3) @(negedge clk);
      ref_p = 1'b0;
      repeat (3) @(negedge clk);
      model(0);
      if (n == 1) check(lock, 1'b0, "R11 held input two cycles");
    end
    check(lock, 1'b1, "R11 held input single edge");

    // sweep: run select x lead order x run separation x follow-up separation
    for (int s = 0; s < 2; s++) begin
      for (int o = 0; o < 2; o++) begin
        for (int ka = 0; ka <= 8; ka++) begin
          for (int kb = 0; kb <= 8; kb++) begin
            int need;
            bit was_locked;
            ldp = s[0];
            need = s ? 5 : 3;
            power_down();
            for (int i = 0; i < need - 1; i++) phase_cycle(o[0], ka);
            check(lock, 1'b0, s ? "R4 short of run" : "R3 short of run");
            phase_cycle(o[0], ka);
            check(lock, exp_lock, s ? "R2/R4 run complete" : "R2/R3 run complete");
            was_locked = exp_lock;
            phase_cycle(o[0], kb);
            if (grade(kb) == 2)   check(lock, exp_lock, "R6 large follow-up");
            else if (was_locked)  check(lock, exp_lock, "R5 hold on follow-up");
            else                  check(lock, exp_lock, "R7 follow-up unlocked");
          end
        end
      end
    end

    summary();
  end

endmodule